// File: doc/BRIEF.md
# Searchable Register-Tag FIFO

This block is a small synchronous queue. It holds decoded instruction templates between the decode stage and the execute stage of an in-order pipeline. The producer pushes a template when the queue has room. The consumer reads the oldest template through a head port that is always visible, and pops it when it is done with it. A flush input empties the queue in one cycle, which is how the pipeline discards wrongly fetched work after a taken branch.

Alongside the queue ports there is a combinational probe. It takes a 5-bit register name and reports whether any template now held in the queue will write that register. Decode uses the probe to stall an instruction whose source operand is still waiting to be produced. Only adds and loads write a register, so only those kinds can raise the probe. The probe looks only at slots that are occupied. A slot that has been popped or flushed never produces a hit, whatever data it still holds.

Top module: `regtag_search_fifo`

## Requirements
- R1: `push_rdy` is low exactly when the queue holds DEPTH entries. A push while the queue is full is ignored, and the held contents and their order are unchanged.
- R2: `pop_rdy` is high exactly when the queue holds at least one entry. A pop while the queue is empty is ignored.
- R3: The head outputs show the oldest held entry without removing it. The head stays stable while no pop and no flush are accepted.
- R4: An accepted pop removes the oldest entry. Entries leave the queue in the order they were pushed.
- R5: After a cycle with `flush_en` high the queue is empty. Flush takes priority over a push or a pop in the same cycle, and that push or pop has no effect.
- R6: `probe_hit` is high when an occupied entry of kind add (code 2'b00) or kind load (code 2'b10) has a destination equal to `probe_reg`.
- R7: An entry of kind branch-if-zero (code 2'b01) or kind store (code 2'b11) never raises `probe_hit`, whatever its destination field holds.
- R8: The probe sees only entries held at the start of the cycle. Freed slots never match, and a template being pushed in the same cycle does not match.
- R9: When the queue is neither empty nor full, a push and a pop can be accepted in the same cycle. The occupancy is then unchanged and both operations take effect.
- R10: After reset the queue is empty: `push_rdy` is high, and `pop_rdy` and `probe_hit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Request to append a template |
| push_kind | input | 2 | Kind of the template: 00 add, 01 branch-if-zero, 10 load, 11 store |
| push_dest | input | 5 | Destination register of the template |
| push_opa | input | 32 | First operand value |
| push_opb | input | 32 | Second operand value |
| push_rdy | output | 1 | The queue has room for a template |
| pop_en | input | 1 | Request to remove the oldest template |
| pop_rdy | output | 1 | The queue holds a template; the head outputs are valid |
| head_kind | output | 2 | Kind of the oldest template |
| head_dest | output | 5 | Destination register of the oldest template |
| head_opa | output | 32 | First operand of the oldest template |
| head_opb | output | 32 | Second operand of the oldest template |
| flush_en | input | 1 | Empty the queue at the next edge |
| probe_reg | input | 5 | Register name to search for |
| probe_hit | output | 1 | Some held template will write `probe_reg` |

## Verification
The probe is tried with the same register name against each of the four kinds, so a predicate that keys on the wrong kind bits shows up as a false hit or a missed hit. It is also tried on a name that sits only in a popped or flushed slot, and on a name carried by a template that is being pushed in the same cycle. These two cases tell an occupancy-qualified search apart from one that scans raw storage or looks at the incoming data. The queue ports are driven at full, at empty, with push and pop together, and with flush together with a push. A random phase then mixes all operations while a scoreboard compares every popped template against the pushed order.

// File: rtl/stf_pkg.sv
// Package: shared types for the searchable register-tag FIFO.
// Assumes templates carry a 2-bit kind, a register name and two operands.
package stf_pkg;

    localparam int REG_W  = 5;
    localparam int OPND_W = 32;

    typedef enum logic [1:0] {
        K_ADD   = 2'b00,
        K_BRZ   = 2'b01,
        K_LOAD  = 2'b10,
        K_STORE = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [REG_W-1:0]    dest;
        logic [OPND_W-1:0]   opa;
        logic [OPND_W-1:0]   opb;
    } tmpl_t;

    // True for kinds whose execution updates a register.
    function automatic logic kind_writes_reg(kind_e k);
        return (k == K_ADD) || (k == K_LOAD);
    endfunction

endpackage

// File: rtl/stf_ptr_ctl.sv
// Module: read/write pointer and occupancy control for a circular buffer.
// Assumes push and pop are already qualified by the caller, and that a
// push is never asserted when full nor a pop when empty. Flush beats both.
module stf_ptr_ctl #(
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic                          flush,
    output logic [$clog2(DEPTH)-1:0]      wr_ptr,
    output logic [$clog2(DEPTH)-1:0]      rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    // Advance a pointer with wrap at DEPTH-1 (DEPTH need not be a power of 2).
    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Update pointers and occupancy for this cycle's accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Derive the full and empty flags from the occupancy.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/stf_slots.sv
// Module: template storage with a per-slot occupied bit.
// Assumes wr_idx and rd_idx are always below DEPTH. Data words are not
// reset; only the occupied bits are, and they alone qualify the contents.
module stf_slots
    import stf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  tmpl_t                      wr_data,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    input  logic                       flush,
    output tmpl_t                      slot   [DEPTH],
    output logic [DEPTH-1:0]           slot_vld,
    output tmpl_t                      head
);
    // Write the incoming template into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    // Track which slots hold a live template.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            slot_vld <= '0;
        end else begin
            if (rd_en) slot_vld[rd_idx] <= 1'b0;
            if (wr_en) slot_vld[wr_idx] <= 1'b1;
        end
    end

    // Present the oldest template.
    always_comb head = slot[rd_idx];

endmodule

// File: rtl/stf_match.sv
// Module: parallel register-tag search over all occupied slots.
// Assumes slot_vld marks exactly the held templates; purely combinational.
module stf_match
    import stf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  tmpl_t               slot   [DEPTH],
    input  logic [DEPTH-1:0]    slot_vld,
    input  logic [REG_W-1:0]    tag,
    output logic                hit
);
    logic [DEPTH-1:0] slot_hit;

    // One comparator per slot, gated by occupancy and the kind rule.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign slot_hit[g] = slot_vld[g]
                           && kind_writes_reg(slot[g].kind)
                           && (slot[g].dest == tag);
    end

    // Reduce the per-slot results to a single flag.
    always_comb hit = |slot_hit;

endmodule

// File: rtl/regtag_search_fifo.sv
// Module: searchable FIFO of decoded instruction templates.
// Assumes a single producer and a single consumer in the same clock domain.
// Flush has priority over push and pop in the same cycle.
module regtag_search_fifo
    import stf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_en,
    input  logic [1:0]           push_kind,
    input  logic [4:0]           push_dest,
    input  logic [31:0]          push_opa,
    input  logic [31:0]          push_opb,
    output logic                 push_rdy,
    input  logic                 pop_en,
    output logic                 pop_rdy,
    output logic [1:0]           head_kind,
    output logic [4:0]           head_dest,
    output logic [31:0]          head_opa,
    output logic [31:0]          head_opb,
    input  logic                 flush_en,
    input  logic [4:0]           probe_reg,
    output logic                 probe_hit
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;
    tmpl_t            in_tmpl;
    tmpl_t            head;
    tmpl_t            slot [DEPTH];
    logic [DEPTH-1:0] slot_vld;

    // Qualify requests with room, contents and flush priority.
    always_comb begin
        do_push = push_en && !full  && !flush_en;
        do_pop  = pop_en  && !empty && !flush_en;
    end

    // Pack the push fields into one template.
    always_comb begin
        in_tmpl.kind = kind_e'(push_kind);
        in_tmpl.dest = push_dest;
        in_tmpl.opa  = push_opa;
        in_tmpl.opb  = push_opb;
    end

    stf_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_push),
        .pop    (do_pop),
        .flush  (flush_en),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .full   (full),
        .empty  (empty)
    );

    stf_slots #(.DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_push),
        .wr_idx   (wr_ptr),
        .wr_data  (in_tmpl),
        .rd_en    (do_pop),
        .rd_idx   (rd_ptr),
        .flush    (flush_en),
        .slot     (slot),
        .slot_vld (slot_vld),
        .head     (head)
    );

    stf_match #(.DEPTH(DEPTH)) u_match (
        .slot     (slot),
        .slot_vld (slot_vld),
        .tag      (probe_reg),
        .hit      (probe_hit)
    );

    // Drive the handshake flags and the head fields.
    always_comb begin
        push_rdy  = !full;
        pop_rdy   = !empty;
        head_kind = head.kind;
        head_dest = head.dest;
        head_opa  = head.opa;
        head_opb  = head.opb;
    end

endmodule

// File: rtl/regtag_search_fifo_chk.sv
// Module: property checker bound to regtag_search_fifo.
// Assumes it observes the top's ports plus its occupancy count and slot bits.
module regtag_search_fifo_chk #(
    parameter int DEPTH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         push_en,
    input logic                         push_rdy,
    input logic                         pop_en,
    input logic                         pop_rdy,
    input logic                         flush_en,
    input logic                         probe_hit,
    input logic [1:0]                   head_kind,
    input logic [4:0]                   head_dest,
    input logic [$clog2(DEPTH+1)-1:0]   count,
    input logic [DEPTH-1:0]             slot_vld
);
    localparam int CW = $clog2(DEPTH + 1);

    // R1: an accepted push leaves the queue non-empty.
    a_r1_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_rdy && !flush_en) |=> pop_rdy);

    // R2: occupancy never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: the head holds still while nothing removes it.
    a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_rdy && !pop_en && !flush_en) |=>
            (pop_rdy && $stable(head_kind) && $stable(head_dest)));

    // R4: the occupied bits agree with the pointer-side count.
    a_r4_vld_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_vld) == int'(count));

    // R5: flush leaves the queue empty with room.
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (!pop_rdy && push_rdy));

    // R8: an empty queue never reports a hit.
    a_r8_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_rdy |-> !probe_hit);

    // R9: simultaneous push and pop keep the occupancy.
    a_r9_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_rdy && pop_en && pop_rdy && !flush_en) |=>
            (count == $past(count)));

endmodule

bind regtag_search_fifo regtag_search_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_rdy  (push_rdy),
    .pop_en    (pop_en),
    .pop_rdy   (pop_rdy),
    .flush_en  (flush_en),
    .probe_hit (probe_hit),
    .head_kind (head_kind),
    .head_dest (head_dest),
    .count     (count),
    .slot_vld  (slot_vld)
);

// File: tb/regtag_search_fifo_tb_top.sv
// Bench: scoreboard for regtag_search_fifo. The driver task pushes expected
// templates into a queue; a monitor pops and compares them on each pop.
module regtag_search_fifo_tb_top;
    import stf_pkg::*;

    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en;
    logic [1:0]  push_kind;
    logic [4:0]  push_dest;
    logic [31:0] push_opa;
    logic [31:0] push_opb;
    logic        push_rdy;
    logic        pop_en;
    logic        pop_rdy;
    logic [1:0]  head_kind;
    logic [4:0]  head_dest;
    logic [31:0] head_opa;
    logic [31:0] head_opb;
    logic        flush_en;
    logic [4:0]  probe_reg;
    logic        probe_hit;

    int    n_chk = 0;
    int    n_bad = 0;
    tmpl_t exp_q[$];

    always #10 clk = ~clk;

    regtag_search_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_kind (push_kind),
        .push_dest (push_dest),
        .push_opa  (push_opa),
        .push_opb  (push_opb),
        .push_rdy  (push_rdy),
        .pop_en    (pop_en),
        .pop_rdy   (pop_rdy),
        .head_kind (head_kind),
        .head_dest (head_dest),
        .head_opa  (head_opa),
        .head_opb  (head_opb),
        .flush_en  (flush_en),
        .probe_reg (probe_reg),
        .probe_hit (probe_hit)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected probe result from the held entries (adds and loads only).
    function automatic bit model_hit(logic [4:0] r);
        foreach (exp_q[i])
            if ((exp_q[i].kind == K_ADD || exp_q[i].kind == K_LOAD) && exp_q[i].dest == r)
                return 1'b1;
        return 1'b0;
    endfunction

    // Monitor: on every accepted pop, compare the head with the oldest expected.
    always @(negedge clk) begin
        if (rst_n && pop_en && pop_rdy && !flush_en) begin
            if (exp_q.size() == 0) begin
                chk("R2", "pop_rdy with empty model", 64'(pop_rdy), 64'd0);
            end else begin
                tmpl_t t;
                t = exp_q.pop_front();
                chk("R4", "popped kind", 64'(head_kind), 64'(t.kind));
                chk("R4", "popped dest", 64'(head_dest), 64'(t.dest));
                chk("R4", "popped opa",  64'(head_opa),  64'(t.opa));
                chk("R4", "popped opb",  64'(head_opb),  64'(t.opb));
            end
        end
    end

    // Driver: apply one cycle of stimulus, check ports, then update the model.
    task automatic step(bit e, kind_e k, logic [4:0] d, logic [31:0] a, logic [31:0] b,
                        bit q, bit c, logic [4:0] s);
        bit    acc_push;
        tmpl_t t;
        push_en = e; push_kind = k; push_dest = d; push_opa = a; push_opb = b;
        pop_en = q; flush_en = c; probe_reg = s;
        #1;
        chk("R1", "push_rdy", 64'(push_rdy), 64'(exp_q.size() < DEPTH));
        chk("R2", "pop_rdy",  64'(pop_rdy),  64'(exp_q.size() > 0));
        // R6 R7 R8: the probe sees held entries only, kind-qualified.
        chk("R6", "probe_hit", 64'(probe_hit), 64'(model_hit(s)));
        if (exp_q.size() > 0) begin
            chk("R3", "head_dest", 64'(head_dest), 64'(exp_q[0].dest));
            chk("R3", "head_kind", 64'(head_kind), 64'(exp_q[0].kind));
        end
        acc_push = e && !c && (exp_q.size() < DEPTH);
        t.kind = k; t.dest = d; t.opa = a; t.opb = b;
        @(posedge clk);
        #2;
        if (c) exp_q.delete();
        else if (acc_push) exp_q.push_back(t);
        push_en = 1'b0; pop_en = 1'b0; flush_en = 1'b0;
    endtask

    task automatic idle_probe(logic [4:0] s, bit exp_hit, string req);
        probe_reg = s;
        #1;
        chk(req, "probe_hit", 64'(probe_hit), 64'(exp_hit));
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        push_en = 1'b0; push_kind = 2'b00; push_dest = '0; push_opa = '0; push_opb = '0;
        pop_en = 1'b0; flush_en = 1'b0; probe_reg = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10", "push_rdy", 64'(push_rdy), 64'd1);
        chk("R10", "pop_rdy",  64'(pop_rdy),  64'd0);
        chk("R10", "probe_hit", 64'(probe_hit), 64'd0);

        // R6: add with dest 3 is found after it is held.
        step(1, K_ADD, 5'd3, 32'h11, 32'h22, 0, 0, 5'd3);
        idle_probe(5'd3, 1'b1, "R6");
        idle_probe(5'd4, 1'b0, "R6");
        // Fill with a load to dest 7; R1 full.
        step(1, K_LOAD, 5'd7, 32'h33, 32'h44, 0, 0, 5'd7);
        chk("R1", "push_rdy when full", 64'(push_rdy), 64'd0);
        idle_probe(5'd7, 1'b1, "R6");
        // R1: push while full is ignored; head stays the add.
        step(1, K_ADD, 5'd9, 32'h55, 32'h66, 0, 0, 5'd9);
        idle_probe(5'd9, 1'b0, "R1");
        chk("R1", "head after ignored push", 64'(head_dest), 64'd3);
        // R4: pop the add; R8: dest 3 now sits only in a freed slot.
        step(0, K_ADD, 5'd0, 32'h0, 32'h0, 1, 0, 5'd3);
        idle_probe(5'd3, 1'b0, "R8");
        chk("R4", "head after pop", 64'(head_dest), 64'd7);
        // R9: push and pop together with one entry held.
        step(1, K_BRZ, 5'd12, 32'h77, 32'h88, 1, 0, 5'd12);
        chk("R9", "pop_rdy after push+pop", 64'(pop_rdy), 64'd1);
        chk("R9", "push_rdy after push+pop", 64'(push_rdy), 64'd1);
        // R7: branch and store to dest 12 never match.
        step(1, K_STORE, 5'd12, 32'h99, 32'haa, 0, 0, 5'd12);
        idle_probe(5'd12, 1'b0, "R7");
        // R5: flush with a push in the same cycle.
        step(0, K_ADD, 5'd0, 32'h0, 32'h0, 1, 0, 5'd0);
        step(1, K_ADD, 5'd20, 32'hbb, 32'hcc, 1, 1, 5'd20);
        chk("R5", "pop_rdy after flush", 64'(pop_rdy), 64'd0);
        idle_probe(5'd20, 1'b0, "R5");
        // R2: pop while empty is ignored.
        step(0, K_ADD, 5'd0, 32'h0, 32'h0, 1, 0, 5'd0);
        chk("R2", "pop_rdy after empty pop", 64'(pop_rdy), 64'd0);
        // R8: same-cycle push is not seen by the probe (checked in step).
        step(1, K_LOAD, 5'd21, 32'hdd, 32'hee, 0, 0, 5'd21);
        idle_probe(5'd21, 1'b1, "R6");
        step(0, K_ADD, 5'd0, 32'h0, 32'h0, 1, 0, 5'd21);

        // Mixed random traffic against the scoreboard.
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom % 2), kind_e'($urandom % 4), 5'($urandom % 8),
                 $urandom, $urandom, 1'($urandom % 2), ($urandom % 16) == 0,
                 5'($urandom % 8));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule